// File: doc/BRIEF.md
# Masked-Write Transmitter PHY Control Bank

This block is a bank of 16-bit control words for a four-lane display transmitter PHY, plus one read-only status word. It sits on a simple 32-bit register bus that has separate write and read strobes. Every write carries its own bit-enable mask. Bit i+16 of the write data allows bit i of the lower half to change. Software can therefore update one field atomically, with no read-modify-write. The analog PHY is outside the block. Its lock indication enters as the `pll_ready` input.

The stored words are decoded continuously into named field outputs:
- lane power-down and idle controls;
- PLL power-down and divider settings;
- rate selection and termination;
- per-lane drive amplitude, amplitude scale and emphasis;
- transmit mode;
- spread-spectrum settings;
- raw PLL and transmit control words;
- AUX channel power, mode and drive settings.

Control word n sits at byte offset 4n for n = 0 to 11. The status word sits at offset 0x30.

Top module: `txphy_ctl_bank`

## Requirements
- R1: A write to control word n updates bit i (i in 0..15) only when `bus_wdata[i+16]` is 1; every other bit of that word, and every other word, keeps its value (a write with an all-zero mask changes nothing).
- R2: Synchronous active-high reset sets word 0 to 0x0FF1 (all lane idle bits, all lane power-down bits and PLL power-down set; IDDQ clear) and word 10 to 0x0007 (AUX idle, AUX receiver and AUX driver power-down set); every other control word resets to 0.
- R3: Word 0 drives `tx_idle` from bits 11:8 (lane n at bit 8+n), `tx_pd` from bits 7:4 (lane n at bit 4+n), `iddq_en` from bit 1 and `pll_pd` from bit 0.
- R4: Word 1 bits 14:0 drive `pll_fbdiv`; word 2 drives `tx_term` from bits 10:8, `rate_sel` from bits 5:4 and `ref_div` from bits 3:0.
- R5: Word 3 holds 4-bit emphasis per lane (lane n at bits 4n+3:4n) and drives `lane_emph` with the same packing; word 4 holds 3-bit amplitude per lane at bits 4n+2:4n, presented on `lane_amp` with lane n at bits 3n+2:3n.
- R6: Word 5 drives `tx_mode` from bits 9:8 and `lane_amp_scale` from bits 2n+1:2n for lane n.
- R7: Word 6 drives `ssc_depth` from bits 15:12, `ssc_en` from bit 11 and `ssc_count` from bits 9:0.
- R8: Words 8 and 9 appear whole on `pll_ctl_hi` and `tx_ctl`. Word 10 drives `aux_rx_pd_sel` (bit 5), `aux_tx_pd_sel` (bit 4), `aux_idle` (bit 2), `aux_rx_pd` (bit 1) and `aux_tx_pd` (bit 0). Word 11 drives `aux_rx_vcm` (14:12), `aux_mode` (11:10), `aux_amp_scale` (9:8), `aux_amp` (6:4) and `aux_term` (2:0).
- R9: A read of offset 0x30 returns `pll_ready` in bit 0 and zero elsewhere; a write to 0x30 changes no control word.
- R10: A read registers its result: `bus_rdata` takes the addressed word in bits 15:0 and zero in bits 31:16 at the clock edge that samples `bus_rd`. It holds that value until the next read. A read and a write to the same word in the same cycle return the value held before the write.
- R11: Offsets that are not 4-byte aligned, or that lie above 0x30, are unmapped: a write there changes no control word and a read there returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 32 | Mask in 31:16, data in 15:0 |
| bus_rdata | output | 32 | Registered read result |
| pll_ready | input | 1 | PLL lock indication from the PHY |
| tx_idle | output | 4 | Per-lane transmit idle |
| tx_pd | output | 4 | Per-lane transmit power-down |
| iddq_en | output | 1 | Quiescent-current test enable |
| pll_pd | output | 1 | PLL power-down |
| pll_fbdiv | output | 15 | PLL feedback divider |
| tx_term | output | 3 | Transmit termination trim |
| rate_sel | output | 2 | Link rate select |
| ref_div | output | 4 | Reference divider |
| lane_emph | output | 16 | Per-lane emphasis, 4 bits each |
| lane_amp | output | 12 | Per-lane amplitude, 3 bits each |
| lane_amp_scale | output | 8 | Per-lane amplitude scale, 2 bits each |
| tx_mode | output | 2 | Transmit mode |
| ssc_depth | output | 4 | Spread-spectrum depth |
| ssc_en | output | 1 | Spread-spectrum enable |
| ssc_count | output | 10 | Spread-spectrum period count |
| pll_ctl_hi | output | 16 | Raw PLL control word |
| tx_ctl | output | 16 | Raw transmit control word |
| aux_rx_pd_sel | output | 1 | AUX receiver power-down source select |
| aux_tx_pd_sel | output | 1 | AUX driver power-down source select |
| aux_idle | output | 1 | AUX idle |
| aux_rx_pd | output | 1 | AUX receiver power-down |
| aux_tx_pd | output | 1 | AUX driver power-down |
| aux_rx_vcm | output | 3 | AUX receiver common-mode trim |
| aux_mode | output | 2 | AUX mode |
| aux_amp_scale | output | 2 | AUX amplitude scale |
| aux_amp | output | 3 | AUX amplitude |
| aux_term | output | 3 | AUX termination trim |

## Verification
A read and a masked write can address the same control word in one cycle. The read must report the word as it stood before the write, while the field outputs show the merged value one edge later. The bench drives `bus_rd` and `bus_wr` together on word 0 with a partial mask and places the old word in the scoreboard for that read. It then issues a second read and checks both that read and the decoded lane idle bits against the merged value. The same scoreboard also covers a read of the status word while `pll_ready` toggles, and reads of unmapped or misaligned offsets after writes to them.

// File: rtl/txphy_ctl_pkg.sv
package txphy_ctl_pkg;

    localparam int ADDR_W   = 8;
    localparam int DATA_W   = 16;
    localparam int BUS_W    = 2 * DATA_W;
    localparam int NUM_CTRL = 12;
    localparam int IDX_W    = ADDR_W - 2;

    typedef logic [DATA_W-1:0] word_t;

    typedef enum logic [IDX_W-1:0] {
        WI_PWR    = 6'd0,
        WI_FBDIV  = 6'd1,
        WI_RATE   = 6'd2,
        WI_EMPH   = 6'd3,
        WI_AMP    = 6'd4,
        WI_MODE   = 6'd5,
        WI_SSC    = 6'd6,
        WI_SPARE  = 6'd7,
        WI_PLLHI  = 6'd8,
        WI_TXCTL  = 6'd9,
        WI_AUXPWR = 6'd10,
        WI_AUXCFG = 6'd11,
        WI_STATUS = 6'd12
    } word_idx_e;

    typedef struct packed {
        logic  en;
        word_t mask;
        word_t data;
    } mwrite_t;

    function automatic mwrite_t unpack_write(input logic en, input logic [BUS_W-1:0] bus);
        mwrite_t r;
        r.en   = en;
        r.mask = bus[BUS_W-1:DATA_W];
        r.data = bus[DATA_W-1:0];
        return r;
    endfunction

    function automatic word_t merge_masked(input word_t old, input mwrite_t w);
        return (old & ~w.mask) | (w.data & w.mask);
    endfunction

    function automatic word_t ctl_reset(input int idx);
        case (idx)
            int'(WI_PWR):    return 16'h0FF1;
            int'(WI_AUXPWR): return 16'h0007;
            default:         return 16'h0000;
        endcase
    endfunction

endpackage

// File: rtl/txphy_ctl_decode.sv
module txphy_ctl_decode
    import txphy_ctl_pkg::*;
#(
    parameter int N_WORDS = NUM_CTRL
) (
    input  logic [ADDR_W-1:0]  addr,
    output logic [N_WORDS-1:0] ctl_sel,
    output logic               status_hit
);
    logic             aligned;
    logic [IDX_W-1:0] idx;

    assign aligned    = (addr[1:0] == 2'b00);
    assign idx        = addr[ADDR_W-1:2];
    assign status_hit = aligned && (idx == WI_STATUS);

    for (genvar i = 0; i < N_WORDS; i++) begin : g_sel
        assign ctl_sel[i] = aligned && (idx == IDX_W'(i));
    end

    always_comb begin
        assert_sel_exclusive_R11 : assert (!(status_hit && (|ctl_sel)) && $onehot0(ctl_sel));
    end
endmodule

// File: rtl/txphy_ctl_word.sv
module txphy_ctl_word
    import txphy_ctl_pkg::*;
#(
    parameter word_t RST_VAL = '0
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    sel,
    input  mwrite_t wr,
    output word_t   q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= RST_VAL;
        else if (wr.en && sel)
            q <= merge_masked(q, wr);
    end

    assert_masked_bits_hold_R1 : assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (((q ^ $past(q)) & ~($past(wr.mask) & {DATA_W{$past(wr.en && sel)}})) == '0));

    assert_reset_value_R2 : assert property (@(posedge clk)
        $fell(rst) |-> (q == RST_VAL));
endmodule

// File: rtl/txphy_ctl_bank.sv
module txphy_ctl_bank
    import txphy_ctl_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [BUS_W-1:0]     bus_wdata,
    output logic [BUS_W-1:0]     bus_rdata,
    input  logic                 pll_ready,
    output logic [LANES-1:0]     tx_idle,
    output logic [LANES-1:0]     tx_pd,
    output logic                 iddq_en,
    output logic                 pll_pd,
    output logic [14:0]          pll_fbdiv,
    output logic [2:0]           tx_term,
    output logic [1:0]           rate_sel,
    output logic [3:0]           ref_div,
    output logic [4*LANES-1:0]   lane_emph,
    output logic [3*LANES-1:0]   lane_amp,
    output logic [2*LANES-1:0]   lane_amp_scale,
    output logic [1:0]           tx_mode,
    output logic [3:0]           ssc_depth,
    output logic                 ssc_en,
    output logic [9:0]           ssc_count,
    output logic [DATA_W-1:0]    pll_ctl_hi,
    output logic [DATA_W-1:0]    tx_ctl,
    output logic                 aux_rx_pd_sel,
    output logic                 aux_tx_pd_sel,
    output logic                 aux_idle,
    output logic                 aux_rx_pd,
    output logic                 aux_tx_pd,
    output logic [2:0]           aux_rx_vcm,
    output logic [1:0]           aux_mode,
    output logic [1:0]           aux_amp_scale,
    output logic [2:0]           aux_amp,
    output logic [2:0]           aux_term
);
    localparam int IDLE_LSB = 8;
    localparam int PD_LSB   = 4;

    mwrite_t                    wreq;
    logic [NUM_CTRL-1:0]        ctl_sel;
    logic                       status_hit;
    word_t [NUM_CTRL-1:0]       words;
    logic [BUS_W-1:0]           rd_next;

    assign wreq = unpack_write(bus_wr, bus_wdata);

    txphy_ctl_decode #(.N_WORDS(NUM_CTRL)) u_decode (
        .addr       (bus_addr),
        .ctl_sel    (ctl_sel),
        .status_hit (status_hit)
    );

    for (genvar i = 0; i < NUM_CTRL; i++) begin : g_word
        txphy_ctl_word #(.RST_VAL(ctl_reset(i))) u_word (
            .clk (clk),
            .rst (rst),
            .sel (ctl_sel[i]),
            .wr  (wreq),
            .q   (words[i])
        );
    end

    // Read path: pre-write word content, registered once.
    always_comb begin
        rd_next = '0;
        if (status_hit)
            rd_next[0] = pll_ready;
        for (int i = 0; i < NUM_CTRL; i++)
            if (ctl_sel[i])
                rd_next[DATA_W-1:0] = words[i];
    end

    always_ff @(posedge clk) begin
        if (rst)
            bus_rdata <= '0;
        else if (bus_rd)
            bus_rdata <= rd_next;
    end

    // Field decode
    assign tx_idle  = words[WI_PWR][IDLE_LSB +: LANES];
    assign tx_pd    = words[WI_PWR][PD_LSB +: LANES];
    assign iddq_en  = words[WI_PWR][1];
    assign pll_pd   = words[WI_PWR][0];

    assign pll_fbdiv = words[WI_FBDIV][14:0];
    assign tx_term   = words[WI_RATE][10:8];
    assign rate_sel  = words[WI_RATE][5:4];
    assign ref_div   = words[WI_RATE][3:0];

    for (genvar n = 0; n < LANES; n++) begin : g_lane
        assign lane_emph[4*n +: 4]      = words[WI_EMPH][4*n +: 4];
        assign lane_amp[3*n +: 3]       = words[WI_AMP][4*n +: 3];
        assign lane_amp_scale[2*n +: 2] = words[WI_MODE][2*n +: 2];
    end

    assign tx_mode   = words[WI_MODE][9:8];
    assign ssc_depth = words[WI_SSC][15:12];
    assign ssc_en    = words[WI_SSC][11];
    assign ssc_count = words[WI_SSC][9:0];

    assign pll_ctl_hi = words[WI_PLLHI];
    assign tx_ctl     = words[WI_TXCTL];

    assign aux_rx_pd_sel = words[WI_AUXPWR][5];
    assign aux_tx_pd_sel = words[WI_AUXPWR][4];
    assign aux_idle      = words[WI_AUXPWR][2];
    assign aux_rx_pd     = words[WI_AUXPWR][1];
    assign aux_tx_pd     = words[WI_AUXPWR][0];

    assign aux_rx_vcm    = words[WI_AUXCFG][14:12];
    assign aux_mode      = words[WI_AUXCFG][11:10];
    assign aux_amp_scale = words[WI_AUXCFG][9:8];
    assign aux_amp       = words[WI_AUXCFG][6:4];
    assign aux_term      = words[WI_AUXCFG][2:0];

    // Checks
    assert_rdata_upper_zero_R10 : assert property (@(posedge clk) disable iff (rst)
        bus_rd |=> (bus_rdata[BUS_W-1:DATA_W] == '0));

    assert_rdata_holds_R10 : assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> $stable(bus_rdata));

    assert_unmapped_read_zero_R11 : assert property (@(posedge clk) disable iff (rst)
        (bus_rd && !status_hit && (ctl_sel == '0)) |=> (bus_rdata == '0));

    assert_unmapped_write_ignored_R11 : assert property (@(posedge clk) disable iff (rst)
        (bus_wr && (ctl_sel == '0)) |=> $stable(words));

    assert_status_read_R9 : assert property (@(posedge clk) disable iff (rst)
        (bus_rd && status_hit) |=> (bus_rdata == {{(BUS_W-1){1'b0}}, $past(pll_ready)}));
endmodule

// File: tb/txphy_ctl_bank_bench.sv
module txphy_ctl_bank_bench;
    import txphy_ctl_pkg::*;

    localparam int LANES = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic pll_ready = 1'b0;
    logic [3:0] tx_idle, tx_pd;
    logic iddq_en, pll_pd;
    logic [14:0] pll_fbdiv;
    logic [2:0] tx_term;
    logic [1:0] rate_sel;
    logic [3:0] ref_div;
    logic [15:0] lane_emph;
    logic [11:0] lane_amp;
    logic [7:0] lane_amp_scale;
    logic [1:0] tx_mode;
    logic [3:0] ssc_depth;
    logic ssc_en;
    logic [9:0] ssc_count;
    logic [15:0] pll_ctl_hi, tx_ctl;
    logic aux_rx_pd_sel, aux_tx_pd_sel, aux_idle, aux_rx_pd, aux_tx_pd;
    logic [2:0] aux_rx_vcm;
    logic [1:0] aux_mode, aux_amp_scale;
    logic [2:0] aux_amp, aux_term;

    always #4 clk = ~clk;

    txphy_ctl_bank #(.LANES(LANES)) u_txphy_ctl_bank (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pll_ready(pll_ready), .tx_idle(tx_idle), .tx_pd(tx_pd),
        .iddq_en(iddq_en), .pll_pd(pll_pd), .pll_fbdiv(pll_fbdiv),
        .tx_term(tx_term), .rate_sel(rate_sel), .ref_div(ref_div),
        .lane_emph(lane_emph), .lane_amp(lane_amp), .lane_amp_scale(lane_amp_scale),
        .tx_mode(tx_mode), .ssc_depth(ssc_depth), .ssc_en(ssc_en),
        .ssc_count(ssc_count), .pll_ctl_hi(pll_ctl_hi), .tx_ctl(tx_ctl),
        .aux_rx_pd_sel(aux_rx_pd_sel), .aux_tx_pd_sel(aux_tx_pd_sel),
        .aux_idle(aux_idle), .aux_rx_pd(aux_rx_pd), .aux_tx_pd(aux_tx_pd),
        .aux_rx_vcm(aux_rx_vcm), .aux_mode(aux_mode), .aux_amp_scale(aux_amp_scale),
        .aux_amp(aux_amp), .aux_term(aux_term)
    );

    int n_checks = 0;
    int n_fail   = 0;

    logic [15:0] mdl [12];
    logic [31:0] exp_q [$];
    string       tag_q [$];
    logic        pend = 1'b0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] expect_rd(input logic [7:0] a);
        if (a[1:0] != 2'b00) return 32'h0;
        if (a == 8'h30) return {31'h0, pll_ready};
        if (a[7:2] < 12) return {16'h0, mdl[a[7:2]]};
        return 32'h0;
    endfunction

    task automatic model_write(input logic [7:0] a, input logic [31:0] d);
        if (a[1:0] == 2'b00 && a[7:2] < 12)
            mdl[a[7:2]] = (mdl[a[7:2]] & ~d[31:16]) | (d[15:0] & d[31:16]);
    endtask

    task automatic wr_word(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        model_write(a, d);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_word(input logic [7:0] a, input string tag);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        exp_q.push_back(expect_rd(a));
        tag_q.push_back(tag);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic rd_wr_same(input logic [7:0] a, input logic [31:0] d, input string tag);
        @(negedge clk);
        bus_rd = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        exp_q.push_back(expect_rd(a));
        tag_q.push_back(tag);
        model_write(a, d);
        @(negedge clk);
        bus_rd = 1'b0; bus_wr = 1'b0;
    endtask

    // Monitor: a read sampled at a posedge is judged at the following negedge.
    always @(posedge clk) pend <= bus_rd && !rst;

    always @(negedge clk) begin
        if (pend) begin
            if (exp_q.size() == 0) begin
                n_checks++; n_fail++;
                $display("FAIL R10: read result with no expected item, actual %h expected none", bus_rdata);
            end else begin
                chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
            end
        end
    end

    task automatic finish_run();
        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            n_checks++; n_fail++;
            $display("FAIL R10: %0d reads without result, actual %0d expected 0", exp_q.size(), exp_q.size());
        end
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: run hung, actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 12; i++) mdl[i] = 16'h0;
        mdl[0]  = 16'h0FF1;
        mdl[10] = 16'h0007;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R2: reset state
        chk("R2 tx_idle", 32'(tx_idle), 32'hF);
        chk("R2 tx_pd", 32'(tx_pd), 32'hF);
        chk("R2 pll_pd/iddq", {30'h0, iddq_en, pll_pd}, 32'h1);
        chk("R2 aux pd/idle", {27'h0, aux_rx_pd_sel, aux_tx_pd_sel, aux_idle, aux_rx_pd, aux_tx_pd}, 32'h7);
        chk("R2 ssc", {ssc_depth, ssc_en, ssc_count}, 32'h0);
        chk("R2 rdata", bus_rdata, 32'h0);
        for (int i = 0; i < 12; i++) rd_word(8'(4*i), "R2 reset word read");

        // R1/R3: partial-mask write to idle nibble only
        wr_word(8'h00, 32'h0F00_0500);
        chk("R3 tx_idle", 32'(tx_idle), 32'h5);
        chk("R1 tx_pd untouched", 32'(tx_pd), 32'hF);
        chk("R1 pll_pd untouched", 32'(pll_pd), 32'h1);
        wr_word(8'h00, 32'h0003_0002);
        chk("R3 iddq_en", 32'(iddq_en), 32'h1);
        chk("R3 pll_pd cleared", 32'(pll_pd), 32'h0);

        // R4
        wr_word(8'h04, 32'h7FFF_4380);
        wr_word(8'h08, 32'h0733_0110);
        chk("R4 pll_fbdiv", 32'(pll_fbdiv), 32'h4380);
        chk("R4 term/rate/ref", {tx_term, rate_sel, ref_div}, {23'h0, 3'd1, 2'd1, 4'd0});
        wr_word(8'h04, 32'h00F0_7FFF);
        chk("R1 partial fbdiv", 32'(pll_fbdiv), 32'h43F0);
        wr_word(8'h04, 32'h0000_0000);
        chk("R1 zero mask", 32'(pll_fbdiv), 32'h43F0);

        // R5, R6
        wr_word(8'h0C, 32'hFFFF_0D84);
        wr_word(8'h10, 32'h7777_7531);
        wr_word(8'h14, 32'h03FF_0355);
        chk("R5 lane_emph", 32'(lane_emph), 32'h0D84);
        chk("R5 lane_amp", 32'(lane_amp), 32'hF59);
        chk("R6 tx_mode", 32'(tx_mode), 32'h3);
        chk("R6 lane_amp_scale", 32'(lane_amp_scale), 32'h55);

        // R7
        wr_word(8'h18, 32'hFBFF_9D7D);
        chk("R7 ssc", {ssc_depth, ssc_en, ssc_count}, {17'h0, 4'h9, 1'b1, 10'h17D});
        wr_word(8'h18, 32'h0800_0000);
        chk("R7 ssc_en off, rest kept", {ssc_depth, ssc_en, ssc_count}, {17'h0, 4'h9, 1'b0, 10'h17D});

        // R8
        wr_word(8'h20, 32'hFFFF_0800);
        wr_word(8'h24, 32'hFFFF_A5A5);
        wr_word(8'h28, 32'h0037_0030);
        wr_word(8'h2C, 32'hFFFF_4531);
        chk("R8 pll_ctl_hi", 32'(pll_ctl_hi), 32'h0800);
        chk("R8 tx_ctl", 32'(tx_ctl), 32'hA5A5);
        chk("R8 aux pwr", {27'h0, aux_rx_pd_sel, aux_tx_pd_sel, aux_idle, aux_rx_pd, aux_tx_pd}, 32'h18);
        chk("R8 aux cfg", {aux_rx_vcm, aux_mode, aux_amp_scale, aux_amp, aux_term}, 32'({3'd4, 2'd1, 2'd1, 3'd3, 3'd1}));

        // R9: status reads and ignored status write
        pll_ready = 1'b0;
        rd_word(8'h30, "R9 status ready=0");
        pll_ready = 1'b1;
        rd_word(8'h30, "R9 status ready=1");
        wr_word(8'h30, 32'hFFFF_FFFF);
        rd_word(8'h30, "R9 status after write");

        // R11: unmapped writes and reads
        wr_word(8'h34, 32'hFFFF_FFFF);
        wr_word(8'h02, 32'hFFFF_0000);
        wr_word(8'h41, 32'hFFFF_1234);
        rd_word(8'h34, "R11 read above status");
        rd_word(8'h06, "R11 misaligned read");
        rd_word(8'hFC, "R11 far read");
        chk("R11 tx_idle kept", 32'(tx_idle), 32'h5);

        // R10: read and write to same word in one cycle
        rd_wr_same(8'h00, 32'h0F00_0A00, "R10 read-during-write returns old");
        rd_word(8'h00, "R10 read after write");
        chk("R10 idle merged", 32'(tx_idle), 32'hA);

        for (int i = 0; i < 12; i++) rd_word(8'(4*i), "R1 final word read");
        finish_run();
    end
endmodule